// File: doc/BRIEF.md
# Two-Wire Serial Row Memory Slave

This block is the slave end of a two-wire serial link that fronts a 512-bit register memory arranged as 32 rows of 16 bits. The master frames every transaction with start and stop conditions. The first byte after a start is a control byte that selects a row and a direction. Row data then moves as byte pairs, low byte first. Reads continue row after row until the master declines to acknowledge. A write is staged in a 16-bit row buffer and committed to the array at the stop condition. A fixed-length internal write cycle follows, and during it the block refuses new control bytes.

Both serial lines are oversampled in the block clock domain. Edges and bus conditions are recovered there. The data line is open drain: the block only ever pulls it low. There is no device address, so the block answers any control byte it receives while it is idle.

Top module: `serial_row_mem`

## Requirements
- R1: After reset the data line is released (`sda_pull_o` = 0), `busy_o` is 0, and every row reads back as 0x0000.
- R2: The control byte is sent MSB first. Bits [7:3] hold the row, bits [2:1] are mode bits that do not change behaviour, and bit 0 gives the direction (1 = read, 0 = write). When the block is not busy it acknowledges by pulling data low during the ninth clock.
- R3: A write takes a low byte and then a high byte, each acknowledged. The row is written with {high, low} at the stop condition, and `busy_o` then rises.
- R4: A write that ends with a stop after only one data byte leaves the row unchanged and starts no write cycle.
- R5: A data byte sent after a complete write pair is not acknowledged and does not alter the row that is committed.
- R6: A read returns the low byte and then the high byte of the row, each MSB first. The block changes the data line only while the clock is low.
- R7: When the master acknowledges a high byte, the read continues with the next row, and the row after 31 is row 0.
- R8: When the master does not acknowledge a read byte, the block releases the data line and stays released until the next start condition.
- R9: After a commit, `busy_o` stays high for WR_CYCLES clocks. A control byte received in that window is not acknowledged. Once `busy_o` falls, control bytes are acknowledged again.
- R10: A repeated start that arrives after a complete write pair but before a stop discards the pair, and the row keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock used to oversample the serial lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock from the master |
| sda_i | input | 1 | Resolved level of the shared data line |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain drive) |
| busy_o | output | 1 | High while the internal write cycle runs |

## Verification
The embedded assertions check several rules on every clock. The data line may change only while the sampled clock is low. A control byte is never acknowledged while the block is busy. The line stays released when the block is idle or has been refused. Every commit both starts the busy window and lands in the addressed row. Other behaviours need whole transactions, and only the bench scenarios show them: byte order within a row, address roll-over from row 31 to row 0, a dropped single byte, an ignored surplus byte, a pair discarded by a repeated start, and a control byte refused during the write cycle.

// File: rtl/srm_pkg.sv
package srm_pkg;
  localparam int ROW_W     = 16;
  localparam int BYTE_W    = 8;
  localparam int CTL_ROW_LSB = 3;
  localparam int CTL_RNW_BIT = 0;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CTRL_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_WR_DONE,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_IGNORE
  } link_st_e;
endpackage

// File: rtl/srm_line_sync.sv
module srm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES:0] scl_q, sda_q;
  logic scl_now, scl_prev, sda_now, sda_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_i};
      sda_q <= {sda_q[STAGES-1:0], sda_i};
    end
  end

  assign scl_now  = scl_q[STAGES-1];
  assign scl_prev = scl_q[STAGES];
  assign sda_now  = sda_q[STAGES-1];
  assign sda_prev = sda_q[STAGES];

  assign scl_o      = scl_now;
  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_prev;
  assign scl_fall_o = ~scl_now & scl_prev;
  // data edges only count as conditions with clock high on both samples
  assign start_o    = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_o     = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/srm_row_array.sv
module srm_row_array #(
  parameter int ROWS  = 32,
  parameter int WIDTH = 16,
  localparam int AW   = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] rows_q [ROWS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ROWS; i++) rows_q[i] <= '0;
    end else if (wr_en_i) begin
      rows_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = rows_q[rd_addr_i];

  assert_write_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rows_q[$past(wr_addr_i)] == $past(wr_data_i));
endmodule

// File: rtl/srm_link_fsm.sv
module srm_link_fsm
  import srm_pkg::*;
#(
  parameter int ROWS = 32,
  localparam int AW  = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_s_i,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             busy_i,
  input  logic [ROW_W-1:0] rd_data_i,
  output logic [AW-1:0]    rd_addr_o,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [ROW_W-1:0] wr_data_o,
  output logic             sda_pull_o
);
  link_st_e          state_q;
  logic [2:0]        bit_q;
  logic              full_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic [AW-1:0]     row_q, row_nxt;
  logic              rnw_q, hi_q, mack_q;
  logic [ROW_W-1:0]  buf_q;

  assign row_nxt   = (row_q == AW'(ROWS - 1)) ? '0 : row_q + 1'b1;
  assign rd_addr_o = (state_q == ST_RD_ACK) ? row_nxt : row_q;
  assign wr_addr_o = row_q;
  assign wr_data_o = buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      full_q     <= 1'b0;
      rx_q       <= '0;
      tx_q       <= '0;
      row_q      <= '0;
      rnw_q      <= 1'b0;
      hi_q       <= 1'b0;
      mack_q     <= 1'b0;
      buf_q      <= '0;
      sda_pull_o <= 1'b0;
      wr_en_o    <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_i) begin
        if (state_q == ST_WR_DONE) wr_en_o <= 1'b1;
        state_q    <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else if (start_i) begin
        state_q    <= ST_CTRL;
        bit_q      <= '0;
        full_q     <= 1'b0;
        sda_pull_o <= 1'b0;
      end else if (scl_rise_i) begin
        case (state_q)
          ST_CTRL, ST_WR_BYTE: begin
            rx_q  <= {rx_q[BYTE_W-2:0], sda_s_i};
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) full_q <= 1'b1;
          end
          ST_RD_ACK: mack_q <= ~sda_s_i;
          default: ;
        endcase
      end else if (scl_fall_i) begin
        case (state_q)
          ST_CTRL: if (full_q) begin
            full_q <= 1'b0;
            if (busy_i) begin
              state_q <= ST_IGNORE;
            end else begin
              row_q      <= AW'(rx_q[BYTE_W-1:CTL_ROW_LSB]);
              rnw_q      <= rx_q[CTL_RNW_BIT];
              sda_pull_o <= 1'b1;
              state_q    <= ST_CTRL_ACK;
            end
          end
          ST_CTRL_ACK: begin
            bit_q <= '0;
            hi_q  <= 1'b0;
            if (rnw_q) begin
              buf_q      <= rd_data_i;
              sda_pull_o <= ~rd_data_i[BYTE_W-1];
              tx_q       <= {rd_data_i[BYTE_W-2:0], 1'b0};
              state_q    <= ST_RD_BYTE;
            end else begin
              sda_pull_o <= 1'b0;
              state_q    <= ST_WR_BYTE;
            end
          end
          ST_WR_BYTE: if (full_q) begin
            full_q <= 1'b0;
            if (hi_q) buf_q[ROW_W-1:BYTE_W] <= rx_q;
            else      buf_q[BYTE_W-1:0]     <= rx_q;
            sda_pull_o <= 1'b1;
            state_q    <= ST_WR_ACK;
          end
          ST_WR_ACK: begin
            sda_pull_o <= 1'b0;
            bit_q      <= '0;
            if (hi_q) state_q <= ST_WR_DONE;
            else begin
              hi_q    <= 1'b1;
              state_q <= ST_WR_BYTE;
            end
          end
          ST_RD_BYTE: begin
            if (bit_q == 3'd7) begin
              sda_pull_o <= 1'b0;
              state_q    <= ST_RD_ACK;
            end else begin
              sda_pull_o <= ~tx_q[BYTE_W-1];
              tx_q       <= {tx_q[BYTE_W-2:0], 1'b0};
            end
            bit_q <= bit_q + 3'd1;
          end
          ST_RD_ACK: begin
            bit_q <= '0;
            if (!mack_q) begin
              sda_pull_o <= 1'b0;
              state_q    <= ST_IGNORE;
            end else if (!hi_q) begin
              hi_q       <= 1'b1;
              sda_pull_o <= ~buf_q[ROW_W-1];
              tx_q       <= {buf_q[ROW_W-2:BYTE_W], 1'b0};
              state_q    <= ST_RD_BYTE;
            end else begin
              hi_q       <= 1'b0;
              row_q      <= row_nxt;
              buf_q      <= rd_data_i;
              sda_pull_o <= ~rd_data_i[BYTE_W-1];
              tx_q       <= {rd_data_i[BYTE_W-2:0], 1'b0};
              state_q    <= ST_RD_BYTE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_drive_scl_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_pull_o) && !$past(start_i) && !$past(stop_i)) |-> !scl_s_i);
  assert_no_ack_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CTRL_ACK) |-> !busy_i);
  assert_released_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE || state_q == ST_IGNORE) |-> !sda_pull_o);
endmodule

// File: rtl/serial_row_mem.sv
module serial_row_mem #(
  parameter int ROWS        = 32,
  parameter int WR_CYCLES   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o,
  output logic busy_o
);
  import srm_pkg::*;
  localparam int AW = $clog2(ROWS);
  localparam int BW = $clog2(WR_CYCLES + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic wr_en;
  logic [AW-1:0]    rd_addr, wr_addr;
  logic [ROW_W-1:0] rd_data, wr_data;
  logic [BW-1:0]    busy_q;

  srm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  srm_link_fsm #(.ROWS(ROWS)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start_ev), .stop_i(stop_ev),
    .busy_i(busy_o), .rd_data_i(rd_data), .rd_addr_o(rd_addr), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .sda_pull_o(sda_pull_o)
  );

  srm_row_array #(.ROWS(ROWS), .WIDTH(ROW_W)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  // fixed-length stand-in for the cell programming time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            busy_q <= '0;
    else if (wr_en)         busy_q <= BW'(WR_CYCLES);
    else if (busy_q != '0)  busy_q <= busy_q - 1'b1;
  end
  assign busy_o = (busy_q != '0);

  assert_commit_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> busy_o);
  assert_busy_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_en));
endmodule

// File: tb/sim_serial_row_mem.sv
module sim_serial_row_mem;
  localparam int WR   = 400;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull, busy;
  logic line;
  int   tests = 0;
  int   fails = 0;
  bit   done = 1'b0;

  assign line = m_sda & ~sda_pull;

  always #4 clk = ~clk;

  serial_row_mem #(.ROWS(32), .WR_CYCLES(WR), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(line),
    .sda_pull_o(sda_pull), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input int n = HALF);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; hw(); scl = 1'b1; hw(); m_sda = 1'b0; hw(); scl = 1'b0; hw(2);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; hw(); scl = 1'b1; hw(); m_sda = 1'b1; hw();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hw(); scl = 1'b1; hw(); scl = 1'b0; hw(2);
    end
    m_sda = 1'b1; hw(); scl = 1'b1; hw(HALF/2);
    ack = (line == 1'b0);
    hw(HALF/2); scl = 1'b0; hw(2);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(); scl = 1'b1; hw(HALF/2); b[i] = line; hw(HALF/2); scl = 1'b0; hw(2);
    end
    m_sda = ~give_ack; hw(); scl = 1'b1; hw(); scl = 1'b0; hw(2); m_sda = 1'b1;
  endtask

  function automatic logic [7:0] ctl(input int row, input logic [1:0] mode, input bit rd);
    return {row[4:0], mode, rd};
  endfunction

  task automatic wait_idle;
    while (busy) @(negedge clk);
  endtask

  task automatic write_row(input int row, input logic [15:0] v, input string req);
    bit a;
    bus_start;
    send_byte(ctl(row, 2'b00, 1'b0), a); check(a, req, a, 1);
    send_byte(v[7:0], a);  check(a, req, a, 1);
    send_byte(v[15:8], a); check(a, req, a, 1);
    bus_stop; wait_idle;
  endtask

  task automatic read_row(input int row, input logic [1:0] mode, output bit a, output logic [15:0] v);
    logic [7:0] lo, hi;
    bus_start;
    send_byte(ctl(row, mode, 1'b1), a);
    recv_byte(1'b1, lo); recv_byte(1'b0, hi);
    bus_stop;
    v = {hi, lo};
  endtask

  task automatic t_reset;
    bit a; logic [15:0] v;
    check(sda_pull == 1'b0, "R1 pull", sda_pull, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    read_row(5, 2'b00, a, v);
    check(a, "R1 ack", a, 1);
    check(v == 16'h0000, "R1 row5", v, 0);
  endtask

  task automatic t_write_read;
    bit a; logic [15:0] v; int n;
    bus_start;
    send_byte(ctl(3, 2'b00, 1'b0), a); check(a, "R2 ctrl ack", a, 1);
    send_byte(8'hEF, a); check(a, "R3 lo ack", a, 1);
    send_byte(8'hBE, a); check(a, "R3 hi ack", a, 1);
    bus_stop;
    check(busy == 1'b1, "R3 busy after stop", busy, 1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(n <= WR && n >= WR - HALF - 6, "R9 busy length", n, WR);
    read_row(3, 2'b11, a, v);
    check(a, "R2 mode bits ignored", a, 1);
    check(v == 16'hBEEF, "R6 byte order", v, 16'hBEEF);
  endtask

  task automatic t_wrap;
    bit a; logic [7:0] b0, b1, b2, b3; int lows;
    write_row(31, 16'h1234, "R3 row31");
    write_row(0, 16'h5678, "R3 row0");
    bus_start;
    send_byte(ctl(31, 2'b01, 1'b1), a); check(a, "R7 ctrl", a, 1);
    recv_byte(1'b1, b0); recv_byte(1'b1, b1); recv_byte(1'b1, b2); recv_byte(1'b0, b3);
    check({b1, b0} == 16'h1234, "R7 row31", {b1, b0}, 16'h1234);
    check({b3, b2} == 16'h5678, "R7 wrap row0", {b3, b2}, 16'h5678);
    lows = 0;
    for (int i = 0; i < 9; i++) begin
      hw(); scl = 1'b1; hw(HALF/2); if (line == 1'b0) lows++; hw(HALF/2); scl = 1'b0; hw(2);
    end
    check(lows == 0, "R8 released after nack", lows, 0);
    bus_stop;
  endtask

  task automatic t_partial;
    bit a; logic [15:0] v;
    bus_start;
    send_byte(ctl(7, 2'b00, 1'b0), a); check(a, "R4 ctrl", a, 1);
    send_byte(8'h99, a); check(a, "R4 lo", a, 1);
    bus_stop; hw(4);
    check(busy == 1'b0, "R4 no write cycle", busy, 0);
    read_row(7, 2'b00, a, v);
    check(v == 16'h0000, "R4 row7 unchanged", v, 0);
  endtask

  task automatic t_extra;
    bit a; logic [15:0] v;
    bus_start;
    send_byte(ctl(8, 2'b10, 1'b0), a);
    send_byte(8'h5A, a); send_byte(8'hA5, a);
    send_byte(8'hFF, a); check(!a, "R5 extra byte nack", a, 0);
    bus_stop; wait_idle;
    read_row(8, 2'b00, a, v);
    check(v == 16'hA55A, "R5 row8", v, 16'hA55A);
    read_row(9, 2'b00, a, v);
    check(v == 16'h0000, "R5 row9 untouched", v, 0);
  endtask

  task automatic t_restart;
    bit a; logic [15:0] v;
    bus_start;
    send_byte(ctl(10, 2'b00, 1'b0), a);
    send_byte(8'h11, a); send_byte(8'h11, a); check(a, "R10 pair ack", a, 1);
    bus_start; bus_stop; hw(4);
    check(busy == 1'b0, "R10 no commit", busy, 0);
    read_row(10, 2'b00, a, v);
    check(v == 16'h0000, "R10 row10", v, 0);
  endtask

  task automatic t_busy_nack;
    bit a; logic [15:0] v;
    bus_start;
    send_byte(ctl(12, 2'b00, 1'b0), a);
    send_byte(8'h0F, a); send_byte(8'h0F, a);
    bus_stop;
    bus_start;
    send_byte(ctl(12, 2'b00, 1'b1), a);
    check(!a, "R9 nack while busy", a, 0);
    check(busy == 1'b1, "R9 still busy", busy, 1);
    bus_stop; wait_idle;
    read_row(12, 2'b00, a, v);
    check(a, "R9 ack after busy", a, 1);
    check(v == 16'h0F0F, "R9 row12", v, 16'h0F0F);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    hw(5); rst_ni = 1'b1; hw(5);
    t_reset;
    t_write_read;
    t_wrap;
    t_partial;
    t_extra;
    t_restart;
    t_busy_nack;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule